// File: doc/BRIEF.md
# Programmable Divider Pair with Phase-Frequency Detector

This block is the digital heart of a synthesizer loop. Everything runs on one system clock. The reference oscillator and the loop oscillator each arrive as single-cycle tick enables. A programmable reference divider turns reference ticks into comparison edges. A programmable feedback divider does the same for the oscillator ticks. A band input picks which of two oscillator tick inputs feeds the feedback divider.

A dual-flip-flop phase-frequency detector compares the two divided edge trains and produces up and down pump pulses. The pulses are meant for an external charge pump and loop filter.

A two-bit pump select is carried to a registered one-hot current-level code for the pump driver. A lock qualifier watches how wide the detector pulses are. It reports lock once a run of comparisons has stayed narrow.

Top module: `pll_div_pfd_core`

## Requirements
- R1: While `rst_n` is low, `pump_up` and `pump_dn` are 0, `locked` is 0 and `pump_cur` is 4'b0001. Both dividers restart from count 0 with a ratio of 2.
- R2: The reference divider emits one divided edge every P reference ticks, where P is the ratio latched from `ref_div`. Ticks that are absent do not advance it. The edge sets `pump_up` on the clock after the edge.
- R3: The feedback divider counts ticks from `am_tick` when `band_am` is 1 and from `fm_tick` when `band_am` is 0. Ticks on the unselected input have no effect. Its divided edge sets `pump_dn` on the clock after the edge.
- R4: A divide word of 0 or 1 on either divider is treated as 2. Any word from 2 to 65535 is used unchanged.
- R5: A new divide word is latched only on the tick that completes the current period. A period already under way is never shortened or stretched.
- R6: Once `pump_up` and `pump_dn` are both 1, both clear on the next clock. A divided edge that arrives in that clearing cycle is not lost: its output is 1 on the following cycle.
- R7: `pump_cur` is a one-hot code registered one clock after `pump_sel`. Bit 0 means 25 uA (code 00), bit 1 means 100 uA (01), bit 2 means 500 uA (10) and bit 3 means 2000 uA (11).
- R8: A comparison ends when both pump outputs are 1. Its width is the number of cycles in which exactly one output was 1. `locked` is 1 after 16 consecutive comparisons of width below 4. A single comparison of width 4 or more clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle enable per reference oscillator period |
| fm_tick | input | 1 | One-cycle enable per FM-band oscillator period |
| am_tick | input | 1 | One-cycle enable per AM-band oscillator period |
| band_am | input | 1 | Feedback source select: 1 = AM tick, 0 = FM tick |
| ref_div | input | 16 | Reference divide word |
| fb_div | input | 16 | Feedback divide word |
| pump_sel | input | 2 | Pump current select code |
| pump_up | output | 1 | Detector up pulse |
| pump_dn | output | 1 | Detector down pulse |
| pump_cur | output | 4 | One-hot pump current level |
| locked | output | 1 | Lock qualifier |

## Verification
Two things can fall in the same cycle. One is the detector's clearing cycle. The other is a freshly registered divided edge from either divider. The case matters because a careless clear would swallow that edge.

The bench provokes the overlap in three ways:
- equal ratios with ticks on every cycle, so both edges coincide;
- mismatched ratios, so one edge lands right after the other;
- long runs of random ticks and random small divide words, including words being swapped mid-period.

A behavioural model built from the requirements predicts every output on every clock. Any divergence, including a dropped edge, shows up as a miscompare at the cycle it happens.

// File: rtl/pll_core_pkg.sv
package pll_core_pkg;

   // number of selectable pump current levels and the select width
   localparam int unsigned PUMP_LEVELS = 4;
   localparam int unsigned PSEL_W      = $clog2(PUMP_LEVELS);

   // select codes, ordered from weakest to strongest pump current
   typedef enum logic [PSEL_W-1:0] {
      IPUMP_25U   = 2'b00,
      IPUMP_100U  = 2'b01,
      IPUMP_500U  = 2'b10,
      IPUMP_2000U = 2'b11
   } pump_sel_e;

   // smallest divide ratio either divider will run at
   localparam int unsigned MIN_RATIO = 2;

endpackage

// File: rtl/pll_prog_div.sv
module pll_prog_div #(
   parameter int unsigned W       = 16,
   parameter int unsigned MIN_DIV = pll_core_pkg::MIN_RATIO
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic [W-1:0] word,
   output logic         edge_o
);

   if (W < 2) begin : g_bad_w
      $error("pll_prog_div: W must be at least 2");
   end
   if (MIN_DIV < 2) begin : g_bad_min
      $error("pll_prog_div: MIN_DIV must be at least 2");
   end

   localparam logic [W-1:0] MIN_V = W'(MIN_DIV);

   logic [W-1:0] cnt_q;
   logic [W-1:0] per_q;
   logic [W-1:0] word_eff;
   logic         last_cnt;
   logic         terminal;
   logic         edge_q;

   // words below the minimum ratio run at the minimum ratio
   assign word_eff = (word < MIN_V) ? MIN_V : word;
   assign last_cnt = (cnt_q == per_q - 1'b1);
   assign terminal = tick && last_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_q  <= MIN_V;
         edge_q <= 1'b0;
      end else begin
         edge_q <= terminal;
         if (tick) begin
            if (last_cnt) begin
               cnt_q <= '0;
               per_q <= word_eff;   // new ratio only at period boundary
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end

   assign edge_o = edge_q;

   // R2
   div_edge_needs_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
      edge_q |-> $past(tick));

   // R2
   div_count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < per_q);

   // R5
   div_reload_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(per_q) |-> $past(tick && cnt_q == per_q - 1'b1));

   // R4
   div_ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      per_q >= MIN_V);

endmodule

// File: rtl/pll_pfd.sv
module pll_pfd (
   input  logic clk,
   input  logic rst_n,
   input  logic ref_edge,
   input  logic fb_edge,
   output logic up_o,
   output logic dn_o
);

   logic up_q;
   logic dn_q;
   logic clr;
   logic up_d;
   logic dn_d;

   // both flops set: the comparison is over, clear together
   assign clr  = up_q && dn_q;
   // an edge landing in the clearing cycle re-arms its own flop
   assign up_d = clr ? ref_edge : (up_q || ref_edge);
   assign dn_d = clr ? fb_edge  : (dn_q || fb_edge);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up_q <= 1'b0;
         dn_q <= 1'b0;
      end else begin
         up_q <= up_d;
         dn_q <= dn_d;
      end
   end

   assign up_o = up_q;
   assign dn_o = dn_q;

   // R6
   pfd_ref_sets_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ref_edge |=> up_q);

   // R6
   pfd_fb_sets_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_edge |=> dn_q);

   // R6
   pfd_up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (up_q && !dn_q) |=> up_q);

endmodule

// File: rtl/pll_lock_det.sv
module pll_lock_det #(
   parameter int unsigned THR = 4,
   parameter int unsigned CNT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic up_i,
   input  logic dn_i,
   output logic locked_o
);

   if (THR < 1) begin : g_bad_thr
      $error("pll_lock_det: THR must be at least 1");
   end
   if (CNT < 1) begin : g_bad_cnt
      $error("pll_lock_det: CNT must be at least 1");
   end

   localparam int unsigned WW = $clog2(THR + 1);
   localparam int unsigned GW = $clog2(CNT + 1);
   localparam logic [WW-1:0] THR_V = WW'(THR);
   localparam logic [GW-1:0] CNT_V = GW'(CNT);

   logic [WW-1:0] wid_q;
   logic [GW-1:0] good_q;
   logic          done;
   logic          one_side;
   logic          narrow;

   assign done     = up_i && dn_i;
   assign one_side = up_i ^ dn_i;
   assign narrow   = (wid_q < THR_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wid_q  <= '0;
         good_q <= '0;
      end else if (done) begin
         wid_q <= '0;
         if (!narrow) begin
            good_q <= '0;
         end else if (good_q != CNT_V) begin
            good_q <= good_q + 1'b1;
         end
      end else if (one_side && (wid_q != THR_V)) begin
         wid_q <= wid_q + 1'b1;   // saturates at the threshold
      end
   end

   assign locked_o = (good_q == CNT_V);

   // R8
   lock_rise_at_compare_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked_o) |-> $past(up_i && dn_i));

   // R8
   lock_drop_on_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !narrow) |=> !locked_o);

endmodule

// File: rtl/pll_div_pfd_core.sv
module pll_div_pfd_core #(
   parameter int unsigned DIV_W    = 16,
   parameter int unsigned LOCK_THR = 4,
   parameter int unsigned LOCK_CNT = 16,
   parameter bit          HAS_LOCK = 1'b1
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic                                   ref_tick,
   input  logic                                   fm_tick,
   input  logic                                   am_tick,
   input  logic                                   band_am,
   input  logic [DIV_W-1:0]                       ref_div,
   input  logic [DIV_W-1:0]                       fb_div,
   input  logic [pll_core_pkg::PSEL_W-1:0]        pump_sel,
   output logic                                   pump_up,
   output logic                                   pump_dn,
   output logic [pll_core_pkg::PUMP_LEVELS-1:0]   pump_cur,
   output logic                                   locked
);

   import pll_core_pkg::*;

   if (DIV_W < 2) begin : g_bad_divw
      $error("pll_div_pfd_core: DIV_W must be at least 2");
   end

   logic                   fb_tick;
   logic                   ref_edge;
   logic                   fb_edge;
   logic [PUMP_LEVELS-1:0] lvl_hit;
   logic [PUMP_LEVELS-1:0] cur_q;

   // feedback routing by band
   assign fb_tick = band_am ? am_tick : fm_tick;

   pll_prog_div #(.W(DIV_W), .MIN_DIV(MIN_RATIO)) u_ref_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (ref_tick),
      .word   (ref_div),
      .edge_o (ref_edge)
   );

   pll_prog_div #(.W(DIV_W), .MIN_DIV(MIN_RATIO)) u_fb_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (fb_tick),
      .word   (fb_div),
      .edge_o (fb_edge)
   );

   pll_pfd u_pfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .ref_edge (ref_edge),
      .fb_edge  (fb_edge),
      .up_o     (pump_up),
      .dn_o     (pump_dn)
   );

   if (HAS_LOCK) begin : g_lock
      pll_lock_det #(.THR(LOCK_THR), .CNT(LOCK_CNT)) u_lock (
         .clk      (clk),
         .rst_n    (rst_n),
         .up_i     (pump_up),
         .dn_i     (pump_dn),
         .locked_o (locked)
      );
   end else begin : g_no_lock
      assign locked = 1'b0;
   end

   // pump current select decoded to one line per level
   for (genvar lv = 0; lv < PUMP_LEVELS; lv++) begin : g_lvl
      assign lvl_hit[lv] = (pump_sel == PSEL_W'(lv));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= PUMP_LEVELS'(1);
      end else begin
         cur_q <= lvl_hit;
      end
   end

   assign pump_cur = cur_q;

   // R7
   cur_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(pump_cur) == 1);

   // R6
   pfd_clear_no_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pump_up && pump_dn) |=> !(pump_up && pump_dn));

   // R3
   fb_edge_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fb_edge |-> $past(band_am ? am_tick : fm_tick));

endmodule

// File: tb/pll_div_pfd_core_tb.sv
`timescale 1ns/1ps
module pll_div_pfd_core_tb_top;

   localparam int THR  = 4;
   localparam int LCNT = 16;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        ref_tick, fm_tick, am_tick, band_am;
   logic [15:0] ref_div, fb_div;
   logic [1:0]  pump_sel;
   logic        pump_up, pump_dn, locked;
   logic [3:0]  pump_cur;

   always #10 clk = ~clk;   // 50 MHz

   pll_div_pfd_core dut_i (
      .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fm_tick(fm_tick),
      .am_tick(am_tick), .band_am(band_am), .ref_div(ref_div), .fb_div(fb_div),
      .pump_sel(pump_sel), .pump_up(pump_up), .pump_dn(pump_dn),
      .pump_cur(pump_cur), .locked(locked)
   );

   int    n_vec  = 0;
   int    n_miss = 0;
   string tag    = "";

   // behavioural reference state
   int m_rcnt, m_rper, m_fcnt, m_fper, m_wid, m_good;
   bit m_rp, m_fp, m_up, m_dn;
   int m_cur;

   function automatic int clampw(input int w);
      return (w < 2) ? 2 : w;
   endfunction

   task automatic model_reset();
      m_rcnt = 0; m_rper = 2; m_fcnt = 0; m_fper = 2;
      m_rp = 0; m_fp = 0; m_up = 0; m_dn = 0;
      m_wid = 0; m_good = 0; m_cur = 1;
   endtask

   task automatic model_step();
      bit fbt, rt, ft, clr;
      clr = m_up && m_dn;
      // lock qualifier from present detector outputs
      if (clr) begin
         m_good = (m_wid < THR) ? ((m_good < LCNT) ? m_good + 1 : LCNT) : 0;
         m_wid  = 0;
      end else if (m_up != m_dn) begin
         m_wid = (m_wid < THR) ? m_wid + 1 : THR;
      end
      // detector from present divided edges
      if (clr) begin
         m_up = m_rp; m_dn = m_fp;
      end else begin
         m_up = m_up || m_rp; m_dn = m_dn || m_fp;
      end
      // dividers
      rt = 0; ft = 0;
      if (ref_tick) begin
         if (m_rcnt == m_rper - 1) begin
            rt = 1; m_rcnt = 0; m_rper = clampw(int'(ref_div));
         end else m_rcnt++;
      end
      fbt = band_am ? am_tick : fm_tick;
      if (fbt) begin
         if (m_fcnt == m_fper - 1) begin
            ft = 1; m_fcnt = 0; m_fper = clampw(int'(fb_div));
         end else m_fcnt++;
      end
      m_rp = rt; m_fp = ft;
      m_cur = 1 << pump_sel;
   endtask

   task automatic compare();
      bit exp_lock;
      exp_lock = (m_good == LCNT);
      n_vec++;
      if (pump_up !== m_up || pump_dn !== m_dn || pump_cur !== 4'(m_cur) ||
          locked !== exp_lock) begin
         n_miss++;
         $display("FAIL [%s] t=%0t up/dn/cur/lock actual %0b %0b %b %0b expected %0b %0b %b %0b",
                  tag, $time, pump_up, pump_dn, pump_cur, locked,
                  m_up, m_dn, 4'(m_cur), exp_lock);
      end
   endtask

   task automatic chk(input string req, input int act, input int exp);
      n_vec++;
      if (act != exp) begin
         n_miss++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cyc();
      if (!rst_n) model_reset(); else model_step();
      @(posedge clk);
      @(negedge clk);
      compare();
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_miss++;
      $display("FAIL watchdog expired (all requirements)");
      finish_run();
   end

   initial begin
      logic [15:0] lf;
      lf = 16'hACE1;
      rst_n = 0; ref_tick = 0; fm_tick = 0; am_tick = 0; band_am = 0;
      ref_div = 16'd4; fb_div = 16'd4; pump_sel = 2'b10;
      model_reset();
      @(negedge clk);

      // R1 reset values
      tag = "R1 reset";
      repeat (3) cyc();
      chk("R1 pump_up in reset", pump_up, 0);
      chk("R1 pump_cur in reset", pump_cur, 1);
      chk("R1 locked in reset", locked, 0);

      // R2 R6 R8: equal ratios, coincident edges
      rst_n = 1; pump_sel = 2'b00;
      tag = "R2 R6 R8 equal ratios";
      ref_tick = 1; fm_tick = 1; ref_div = 16'd4; fb_div = 16'd4;
      repeat (200) cyc();
      chk("R8 locked after narrow comparisons", locked, 1);

      // R4 clamp of small words
      tag = "R4 clamp";
      ref_div = 16'd2; fb_div = 16'd0;
      repeat (100) cyc();
      chk("R4 word 0 runs as 2", locked, 1);
      fb_div = 16'd1;
      repeat (60) cyc();
      chk("R4 word 1 runs as 2", locked, 1);

      // R8 mismatch must unlock
      tag = "R8 unlock";
      fb_div = 16'd9;
      repeat (200) cyc();
      chk("R8 locked cleared by wide comparisons", locked, 0);

      // R5 word swaps mid-period
      tag = "R5 reload";
      ref_div = 16'd6; fb_div = 16'd6;
      repeat (31) cyc();
      ref_div = 16'd3;
      repeat (2) cyc();
      ref_div = 16'd6; fb_div = 16'd5;
      repeat (3) cyc();
      fb_div = 16'd6;
      repeat (200) cyc();

      // R3 band routing
      tag = "R3 band";
      band_am = 1; am_tick = 1; fm_tick = 0;
      repeat (150) cyc();
      am_tick = 0; fm_tick = 1;
      repeat (50) cyc();
      chk("R3 fm ticks ignored in AM band, pump_dn", pump_dn, 0);
      chk("R3 fm ticks ignored in AM band, pump_up", pump_up, 1);

      // R7 current level code
      tag = "R7 current";
      for (int s = 0; s < 4; s++) begin
         pump_sel = 2'(s);
         cyc();
         chk("R7 pump_cur one-hot", pump_cur, 1 << s);
      end

      // R2 large ratio
      tag = "R2 large ratio";
      band_am = 0; fm_tick = 1; am_tick = 0; ref_div = 16'd300; fb_div = 16'd300;
      repeat (1500) cyc();

      // mixed random traffic
      tag = "R2 R3 R4 R5 R6 R7 R8 random";
      for (int i = 0; i < 4000; i++) begin
         lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
         ref_tick = lf[0]; fm_tick = lf[3]; am_tick = lf[7];
         if ((i % 64) == 0) begin
            ref_div  = 16'(lf[3:0] % 10);
            fb_div   = 16'(lf[7:4] % 10);
            band_am  = lf[9];
            pump_sel = lf[12:11];
         end
         cyc();
      end

      finish_run();
   end

endmodule